// File: doc/BRIEF.md
# Conditional Data-Processing Unit with Stored Flags

This block is the arithmetic and logic stage of a small 32-bit integer core. Each cycle it takes one operation: a 4-bit predicate code, a 4-bit operation code and a set-flags bit, plus two operands. The second operand has already been through an external shifter, which also supplies its carry-out. The block holds four status flags: negative, zero, carry and overflow. It tests the predicate against those stored flags, and that test decides whether the operation takes effect.

When the predicate holds, the unit computes the result. For ordinary operations it raises a write-enable towards the register file. It updates the flags on the next rising edge if the set-flags bit asks for it, and always for the four compare-style operations. When the predicate fails, the cycle still passes, but nothing is written and the flags stay as they were. The result is combinational. The flags are registered and can be read on `flags_o`.

Top module: `cond_alu_unit`

## Requirements
- R1: The predicate code decodes against stored flags as: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0, 8 C=1 and Z=0, 9 C=0 or Z=1, 10 N==V, 11 N!=V, 12 Z=0 and N==V, 13 Z=1 or N!=V, 14 always. `exec_o` shows the outcome.
- R2: Predicate code 15 never executes: no write-enable and no flag change.
- R3: When the predicate fails, `wr_en_o` is 0 and `flags_o` is unchanged after the next edge.
- R4: The arithmetic codes are 4 a+b, 5 a+b+C, 2 a-b, 6 a-b+C-1, 3 b-a and 7 b-a+C-1. Each is modulo 2^32 on `result_o`.
- R5: The logical codes are 0 a AND b, 1 a XOR b, 12 a OR b and 14 a AND NOT b. Code 13 passes b and code 15 passes NOT b, and both ignore operand a.
- R6: Codes 8 (a AND b), 9 (a XOR b), 10 (a-b) and 11 (a+b) never assert `wr_en_o`. When executed, they always update the flags, whatever the set-flags bit.
- R7: A non-compare operation with the set-flags bit at 0 leaves the flags unchanged.
- R8: On a flag update, N takes bit 31 of the result, and Z is 1 exactly when the result is zero.
- R9: For arithmetic updates, C is the carry out of bit 31. For subtractions this makes C=1 mean no borrow.
- R10: For logical, move and test updates, C takes `shcarry_i` and V keeps its previous value.
- R11: For arithmetic updates, V is 1 exactly when the signed two's-complement result overflows.
- R12: Synchronous active-low reset clears all flags to 0. Flags change only on a rising edge.
- R13: An executed non-compare operation asserts `wr_en_o` in the same cycle.
- `flags_o` packs the flags as bit 3 N, bit 2 Z, bit 1 C, bit 0 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 4 | Predicate code |
| op_i | input | 4 | Operation code |
| setflags_i | input | 1 | Request flag update for non-compare operations |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| shcarry_i | input | 1 | Carry-out of the external shifter |
| result_o | output | 32 | Operation result, valid when `wr_en_o` is 1 |
| wr_en_o | output | 1 | Result write-enable |
| exec_o | output | 1 | Predicate passed this cycle |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions take for granted that every input is a known value on every clock after reset. They also assume an operation is presented every cycle, with no idle encoding. They further rely on the fact that the flags seen at a clock edge are the ones the predicate was tested against in that cycle. The stimulus drives all inputs from a single task just after the falling edge, so they never change near the active edge. It mixes directed flag setups covering every predicate code with random operations whose operands are often drawn from the sign and carry boundary values.

// File: rtl/cond_alu_pkg.sv
// Shared operation codes, flag layout and decode helpers for the
// conditional data-processing unit. Assumes a 4-bit operation space.
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Compare-style operations: flags only, no write.
    function automatic logic op_is_compare(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    // Operations whose flags come from the adder.
    function automatic logic op_is_arith(input logic [3:0] op);
        return (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
    endfunction

endpackage

// File: rtl/cond_alu_cond.sv
// Predicate evaluator: decides whether the current operation takes effect,
// given the stored flags. Purely combinational; code 15 never passes.
module cond_alu_cond
    import cond_alu_pkg::*;
(
    input  nzcv_t      flags_i,
    input  logic [3:0] cond_i,
    output logic       pass_o
);
    logic n_eq_v;

    // Signed-compare helper term.
    always_comb n_eq_v = (flags_i.n == flags_i.v);

    // Predicate table.
    always_comb begin
        unique case (cond_i)
            4'h0: pass_o = flags_i.z;
            4'h1: pass_o = !flags_i.z;
            4'h2: pass_o = flags_i.c;
            4'h3: pass_o = !flags_i.c;
            4'h4: pass_o = flags_i.n;
            4'h5: pass_o = !flags_i.n;
            4'h6: pass_o = flags_i.v;
            4'h7: pass_o = !flags_i.v;
            4'h8: pass_o = flags_i.c && !flags_i.z;
            4'h9: pass_o = !flags_i.c || flags_i.z;
            4'hA: pass_o = n_eq_v;
            4'hB: pass_o = !n_eq_v;
            4'hC: pass_o = !flags_i.z && n_eq_v;
            4'hD: pass_o = flags_i.z || !n_eq_v;
            4'hE: pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_alu_adder.sv
// Shared adder for all arithmetic and compare operations. Selects and
// inverts operands and picks the carry-in per operation; subtraction is
// x + ~y + 1 so carry-out reads as "no borrow". Assumes WIDTH >= 2.
module cond_alu_adder
    import cond_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x, y;
    logic             cin;
    logic [WIDTH:0]   full;

    // Operand routing and carry-in per operation.
    always_comb begin
        x   = a_i;
        y   = b_i;
        cin = 1'b0;
        case (op_i)
            OP_ADD, OP_CMN: begin x = a_i; y = b_i;  cin = 1'b0; end
            OP_ADC:         begin x = a_i; y = b_i;  cin = c_i;  end
            OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; cin = 1'b1; end
            OP_SBC:         begin x = a_i; y = ~b_i; cin = c_i;  end
            OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
            OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i;  end
            default:        begin x = a_i; y = b_i;  cin = 1'b0; end
        endcase
    end

    // One wide add gives sum and carry.
    always_comb full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

    // Outputs: signed overflow when like-signed inputs give an unlike sign.
    always_comb begin
        sum_o  = full[MSB:0];
        cout_o = full[WIDTH];
        ovf_o  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
    end
endmodule

// File: rtl/cond_alu_flagreg.sv
// Stored status flags. Synchronous active-low reset to zero; loads the
// new flags on a rising edge when the load enable is high.
module cond_alu_flagreg
    import cond_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  nzcv_t next_i,
    output nzcv_t flags_o
);
    nzcv_t state;

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= '0;
        else if (load_i) state <= next_i;
    end

    always_comb flags_o = state;
endmodule

// File: rtl/cond_alu_unit.sv
// Conditional data-processing unit: predicate test, result mux over
// logical/move/adder paths, write-enable and flag update control.
// Assumes operand b and its shifter carry arrive already computed.
module cond_alu_unit
    import cond_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cond_i,
    input  logic [3:0]       op_i,
    input  logic             setflags_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             shcarry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic             exec_o,
    output logic [3:0]       flags_o
);
    localparam int MSB = WIDTH - 1;

    nzcv_t            cur_flags, new_flags;
    logic             pass, is_cmp, is_arith, flag_load;
    logic [WIDTH-1:0] sum, res;
    logic             cout, ovf;

    cond_alu_cond u_cond (
        .flags_i (cur_flags),
        .cond_i  (cond_i),
        .pass_o  (pass)
    );

    cond_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .op_i   (op_i),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .c_i    (cur_flags.c),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    // Operation class decode.
    always_comb begin
        is_cmp   = op_is_compare(op_i);
        is_arith = op_is_arith(op_i);
    end

    // Result selection across logical, move and adder paths.
    always_comb begin
        case (op_i)
            OP_AND, OP_TST: res = opa_i & opb_i;
            OP_EOR, OP_TEQ: res = opa_i ^ opb_i;
            OP_ORR:         res = opa_i | opb_i;
            OP_BIC:         res = opa_i & ~opb_i;
            OP_MOV:         res = opb_i;
            OP_MVN:         res = ~opb_i;
            default:        res = sum;
        endcase
    end

    // Next flag values from the selected result.
    always_comb begin
        new_flags.n = res[MSB];
        new_flags.z = (res == '0);
        new_flags.c = is_arith ? cout : shcarry_i;
        new_flags.v = is_arith ? ovf  : cur_flags.v;
    end

    // Execution control: write and flag load gated by the predicate.
    always_comb begin
        flag_load = pass && (setflags_i || is_cmp);
        wr_en_o   = pass && !is_cmp;
        exec_o    = pass;
        result_o  = res;
        flags_o   = cur_flags;
    end

    cond_alu_flagreg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (flag_load),
        .next_i  (new_flags),
        .flags_o (cur_flags)
    );
endmodule

// File: rtl/cond_alu_checker.sv
// Port-level properties for cond_alu_unit, attached with bind.
// Assumes inputs are known on every clock after reset.
module cond_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cond_i,
    input logic [3:0]       op_i,
    input logic             setflags_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_en_o,
    input logic             exec_o,
    input logic [3:0]       flags_o
);
    logic was_rst;
    logic cmp_op, logic_op;

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Operation classes recomputed from the code values in the requirements.
    always_comb begin
        cmp_op   = (op_i == 4'h8) || (op_i == 4'h9) || (op_i == 4'hA) || (op_i == 4'hB);
        logic_op = (op_i == 4'h0) || (op_i == 4'h1) || (op_i == 4'h8) || (op_i == 4'h9) ||
                   (op_i >= 4'hC);
    end

    assert_always_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i == 4'hE |-> exec_o);

    assert_never_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i == 4'hF |-> (!exec_o && !wr_en_o));

    assert_fail_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |-> !wr_en_o);

    assert_fail_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> $stable(flags_o));

    assert_move_passes_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == 4'hD) |-> result_o == opb_i);

    assert_compare_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_op |-> !wr_en_o);

    assert_noset_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!setflags_i && !cmp_op) |=> $stable(flags_o));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && setflags_i && !cmp_op) |=> flags_o[2] == ($past(result_o) == '0));

    assert_logic_keeps_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && logic_op) |=> flags_o[0] == $past(flags_o[0]));

    assert_reset_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> flags_o == 4'h0);

    assert_exec_writes_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && !cmp_op) |-> wr_en_o);
endmodule

bind cond_alu_unit cond_alu_checker #(.WIDTH(WIDTH)) u_cond_alu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond_i),
    .op_i       (op_i),
    .setflags_i (setflags_i),
    .opb_i      (opb_i),
    .result_o   (result_o),
    .wr_en_o    (wr_en_o),
    .exec_o     (exec_o),
    .flags_o    (flags_o)
);

// File: tb/cond_alu_unit_bench.sv
// Self-checking bench: behavioural reference model compared every cycle.
module cond_alu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_i = 4'hE;
    logic [3:0]  op_i = 4'hD;
    logic        setflags_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        shcarry_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o, exec_o;
    logic [3:0]  flags_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic [3:0] mflags = 4'h0;

    always #4 clk = ~clk;

    cond_alu_unit u_cond_alu_unit (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .op_i(op_i),
        .setflags_i(setflags_i), .opa_i(opa_i), .opb_i(opb_i),
        .shcarry_i(shcarry_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .exec_o(exec_o), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit pred(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && n == v;
            13: return z || n != v;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    // Behavioural model: integer arithmetic, carry/overflow from ranges.
    task automatic model(input logic [3:0] op, input logic [31:0] a, b,
                         input bit cf, sh, vf,
                         output logic [31:0] r, output bit c, v, ar);
        longint ua = longint'(a), ub = longint'(b);
        longint sa = longint'($signed(a)), sb = longint'($signed(b));
        longint ur = 0, sr = 0;
        bit sub = 0;
        ar = 1;
        case (op)
            4'h4, 4'hB: begin ur = ua + ub; sr = sa + sb; end
            4'h5: begin ur = ua + ub + cf; sr = sa + sb + cf; end
            4'h2, 4'hA: begin ur = ua - ub; sr = sa - sb; sub = 1; end
            4'h6: begin ur = ua - ub - (1 - cf); sr = sa - sb - (1 - cf); sub = 1; end
            4'h3: begin ur = ub - ua; sr = sb - sa; sub = 1; end
            4'h7: begin ur = ub - ua - (1 - cf); sr = sb - sa - (1 - cf); sub = 1; end
            default: ar = 0;
        endcase
        if (ar) begin
            r = ur[31:0];
            c = sub ? (ur >= 0) : (ur >= 64'sd4294967296);
            v = (sr < -64'sd2147483648) || (sr > 64'sd2147483647);
        end else begin
            case (op)
                4'h0, 4'h8: r = a & b;
                4'h1, 4'h9: r = a ^ b;
                4'hC: r = a | b;
                4'hE: r = a & ~b;
                4'hD: r = b;
                default: r = ~b;
            endcase
            c = sh;
            v = vf;
        end
    endtask

    task automatic do_op(input logic [3:0] cnd, op, input bit s,
                         input logic [31:0] a, b, input bit sh);
        logic [31:0] r;
        bit c, v, ar, pass, comp, upd;
        @(negedge clk);
        cond_i = cnd; op_i = op; setflags_i = s; opa_i = a; opb_i = b; shcarry_i = sh;
        #2;
        pass = pred(cnd, mflags);
        comp = (op[3:2] == 2'b10);
        model(op, a, b, mflags[1], sh, mflags[0], r, c, v, ar);
        if (!pass) chk(cnd == 4'hF ? "R2" : "R1", {31'b0, wr_en_o}, 32'd0);
        else if (comp) chk("R6", {31'b0, wr_en_o}, 32'd0);
        else chk("R13", {31'b0, wr_en_o}, 32'd1);
        if (pass && !comp) chk(ar ? "R4" : "R5", result_o, r);
        @(posedge clk);
        #1;
        upd = pass && (s || comp);
        if (!pass) chk(cnd == 4'hF ? "R2" : "R3", {28'b0, flags_o}, {28'b0, mflags});
        else if (!upd) chk("R7", {28'b0, flags_o}, {28'b0, mflags});
        else begin
            mflags = {r[31], r == 32'd0, c, v};
            chk("R8", {30'b0, flags_o[3:2]}, {30'b0, mflags[3:2]});
            chk(ar ? "R9" : "R10", {31'b0, flags_o[1]}, {31'b0, mflags[1]});
            chk(ar ? "R11" : "R10", {31'b0, flags_o[0]}, {31'b0, mflags[0]});
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7FFF_FFFF;
            3: return 32'hFFFF_FFFF;
            4: return 32'h0000_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", {28'b0, flags_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12", {28'b0, flags_o}, 32'd0);

        // Directed arithmetic boundaries.
        do_op(4'hE, 4'hA, 0, 32'd5, 32'd5, 0);                  // CMP equal: Z, C
        do_op(4'h0, 4'h4, 0, 32'd2, 32'd3, 0);                  // executes on Z
        do_op(4'h1, 4'h4, 1, 32'd2, 32'd3, 0);                  // fails on Z
        do_op(4'hE, 4'h2, 1, 32'd3, 32'd5, 0);                  // borrow: C=0, N=1
        do_op(4'hE, 4'h4, 1, 32'h7FFF_FFFF, 32'd1, 0);          // signed overflow
        do_op(4'hE, 4'h4, 1, 32'hFFFF_FFFF, 32'd1, 0);          // carry out, zero
        do_op(4'hE, 4'h5, 1, 32'd10, 32'd20, 0);                // add with carry in
        do_op(4'hE, 4'h6, 1, 32'd10, 32'd3, 0);
        do_op(4'hE, 4'h7, 1, 32'd3, 32'd10, 1);
        do_op(4'hE, 4'h3, 1, 32'd1, 32'h8000_0000, 0);
        // Logical, moves ignoring a, tests.
        do_op(4'hE, 4'hD, 1, 32'hDEAD_BEEF, 32'h0, 1);
        do_op(4'hE, 4'hF, 1, 32'h1234_5678, 32'h0, 0);
        do_op(4'hE, 4'hE, 1, 32'hFF00_FF00, 32'h0F0F_0F0F, 1);
        do_op(4'hE, 4'h9, 0, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0);
        do_op(4'hE, 4'h8, 0, 32'h8000_0000, 32'hFFFF_FFFF, 1);
        do_op(4'hE, 4'hC, 0, 32'h1, 32'h2, 1);                  // no S: flags kept
        // Every predicate code under several flag states.
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: do_op(4'hE, 4'hA, 0, 32'h8000_0000, 32'd1, 0);
                1: do_op(4'hE, 4'hA, 0, 32'd0, 32'd1, 0);
                2: do_op(4'hE, 4'hA, 0, 32'd1, 32'd1, 0);
                default: do_op(4'hE, 4'hA, 0, 32'd7, 32'd2, 0);
            endcase
            for (int cc = 0; cc < 16; cc++)
                do_op(4'(cc), 4'hD, 0, 32'd0, 32'(cc + 100), 0);
        end
        // Random mix.
        for (int i = 0; i < 600; i++)
            do_op(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  bit'($urandom_range(0, 1)), pick(), pick(), bit'($urandom_range(0, 1)));
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule